// File: doc/BRIEF.md
# Decode-Stage Branch Resolver

This block settles conditional branches and unconditional jumps while the instruction is still in the decode stage of a five-stage in-order pipeline. Fetch always assumes fall-through and keeps going at the next sequential address. The condition compare and the target adder both sit in decode, so a taken transfer is known one cycle after its fetch. At that point exactly one wrong-path instruction has entered the fetch/decode register, and the block squashes it. A transfer that is not taken costs no cycles.

The pipeline passes in the decoded transfer kind, two operand values that have already been bypassed, the address of the decoding instruction, a sign-extended immediate and the word that fetch is about to latch. The block returns four results in the same cycle: the taken decision, the redirect target, the link value and the next-PC select. It also returns the word the fetch/decode register should capture, which is a no-op on a squash. Two saturating counters record resolved transfers and taken transfers, so a cycles-per-instruction figure can be worked out.

Top module: `branch_resolve_unit`

## Requirements
- R1: Kind code 1 (equal) is taken when opA equals opB. Kind code 2 (not equal) is taken when they differ.
- R2: Kind code 3 (less, signed) is taken when opA < opB as two's-complement values. Kind code 4 (greater-or-equal, signed) is taken otherwise.
- R3: Kind code 5 (less, unsigned) is taken when opA < opB as unsigned values. Kind code 6 (greater-or-equal, unsigned) is taken otherwise.
- R4: For kind codes 1 to 7, targetOut equals idPc + immVal modulo 2^32, and this holds for negative immediates.
- R5: Kind code 7 (direct jump) is always taken, and linkOut equals idPc + 4.
- R6: Kind code 8 (register jump) is always taken. Its targetOut equals opA + immVal with bit 0 forced to 0.
- R7: pcSel and flushOut are 1 in the same cycle as takenOut and at no other time. Kind code 0, codes 9 to 15, a condition that fails, and idValid = 0 all give no redirect.
- R8: ifidNext equals the no-op word 0x00000013 while flushOut is 1. Otherwise it equals ifInstr.
- R9: brCount rises by one at the clock edge that ends a cycle with idValid = 1 and a kind code from 1 to 8.
- R10: takenCount rises by one at the clock edge that ends a cycle in which takenOut is 1.
- R11: Both counters hold at their all-ones value instead of wrapping.
- R12: While rstN is 0 both counters read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| idValid | input | 1 | Decode stage holds a real instruction |
| brKind | input | 4 | Transfer kind code (see R1 to R7) |
| opA | input | 32 | First bypassed operand, jump base register |
| opB | input | 32 | Second bypassed operand |
| idPc | input | 32 | Address of the decoding instruction |
| immVal | input | 32 | Sign-extended immediate |
| ifInstr | input | 32 | Word fetch presents to the fetch/decode register |
| takenOut | output | 1 | Transfer is taken |
| targetOut | output | 32 | Redirect address |
| linkOut | output | 32 | Return address for jumps |
| pcSel | output | 1 | 1 selects targetOut as next PC, 0 selects sequential |
| flushOut | output | 1 | Squash the instruction in fetch/decode |
| ifidNext | output | 32 | Word for the fetch/decode register to capture |
| brCount | output | 32 | Saturating count of resolved transfers |
| takenCount | output | 32 | Saturating count of taken transfers |

## Verification
The decision, target, link, select, flush and captured word are combinational and due in the same cycle the decode inputs are driven. The bench drives those inputs just after a falling edge and compares them one time unit later, before any rising edge. The counters are due at the next rising edge. They are compared one time unit after that edge against model totals that the bench updates at the same edge. A second instance with narrow counters reaches the all-ones value inside the run, so the hold-at-maximum behaviour is checked directly.

// File: rtl/bru_pkg.sv
package bru_pkg;

  typedef enum logic [3:0] {
    KIND_NONE = 4'd0,
    KIND_EQ   = 4'd1,
    KIND_NE   = 4'd2,
    KIND_LT   = 4'd3,
    KIND_GE   = 4'd4,
    KIND_LTU  = 4'd5,
    KIND_GEU  = 4'd6,
    KIND_JMP  = 4'd7,
    KIND_JREG = 4'd8
  } br_kind_e;

  typedef struct packed {
    logic eq;
    logic ltS;
    logic ltU;
  } cmp_flags_t;

  typedef struct packed {
    logic redirect;
    logic squash;
    logic regBase;
    logic clearLsb;
    logic countBranch;
  } strobe_t;

endpackage

// File: rtl/bru_ctrl.sv
module bru_ctrl
  import bru_pkg::*;
(
  input  logic       idValid,
  input  logic [3:0] brKind,
  input  cmp_flags_t flags,
  output strobe_t    strobe,
  output logic       takenOut
);

  br_kind_e kind;
  logic     isXfer;
  logic     condMet;

  always_comb begin
    kind    = br_kind_e'(brKind);
    isXfer  = 1'b1;
    condMet = 1'b0;
    unique case (kind)
      KIND_EQ:   condMet = flags.eq;
      KIND_NE:   condMet = !flags.eq;
      KIND_LT:   condMet = flags.ltS;
      KIND_GE:   condMet = !flags.ltS;
      KIND_LTU:  condMet = flags.ltU;
      KIND_GEU:  condMet = !flags.ltU;
      KIND_JMP:  condMet = 1'b1;
      KIND_JREG: condMet = 1'b1;
      default: begin
        isXfer  = 1'b0;
        condMet = 1'b0;
      end
    endcase
  end

  always_comb begin
    strobe.redirect    = idValid && isXfer && condMet;
    strobe.squash      = idValid && isXfer && condMet;
    strobe.regBase     = (kind == KIND_JREG);
    strobe.clearLsb    = (kind == KIND_JREG);
    strobe.countBranch = idValid && isXfer;
    takenOut           = strobe.redirect;
  end

endmodule

// File: rtl/bru_datapath.sv
module bru_datapath
  import bru_pkg::*;
#(
  parameter int          XLEN     = 32,
  parameter int          CNT_W    = 32,
  parameter logic [31:0] NOP_WORD = 32'h0000_0013,
  parameter int          PC_STEP  = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  strobe_t          strobe,
  input  logic [XLEN-1:0]  opA,
  input  logic [XLEN-1:0]  opB,
  input  logic [XLEN-1:0]  idPc,
  input  logic [XLEN-1:0]  immVal,
  input  logic [31:0]      ifInstr,
  output cmp_flags_t       flags,
  output logic [XLEN-1:0]  targetOut,
  output logic [XLEN-1:0]  linkOut,
  output logic [31:0]      ifidNext,
  output logic [CNT_W-1:0] brCount,
  output logic [CNT_W-1:0] takenCount
);

  localparam int          NUM_CNT = 2;
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
  localparam logic [XLEN-1:0]  STEP    = XLEN'(PC_STEP);

  logic [XLEN-1:0] addBase;
  logic [XLEN-1:0] addSum;

  always_comb begin
    flags.eq  = (opA == opB);
    flags.ltS = ($signed(opA) < $signed(opB));
    flags.ltU = (opA < opB);
  end

  always_comb begin
    addBase   = strobe.regBase ? opA : idPc;
    addSum    = addBase + immVal;
    targetOut = strobe.clearLsb ? {addSum[XLEN-1:1], 1'b0} : addSum;
    linkOut   = idPc + STEP;
    ifidNext  = strobe.squash ? NOP_WORD : ifInstr;
  end

  logic [NUM_CNT-1:0] incEn;
  logic [CNT_W-1:0]   cntQ [NUM_CNT];

  assign incEn = {strobe.redirect, strobe.countBranch};

  for (genvar g = 0; g < NUM_CNT; g++) begin : g_cnt
    always_ff @(posedge clk) begin
      if (!rstN) begin
        cntQ[g] <= '0;
      end else if (incEn[g] && (cntQ[g] != CNT_MAX)) begin
        cntQ[g] <= cntQ[g] + {{(CNT_W-1){1'b0}}, 1'b1};
      end
    end
  end

  assign brCount    = cntQ[0];
  assign takenCount = cntQ[1];

endmodule

// File: rtl/branch_resolve_unit.sv
module branch_resolve_unit
  import bru_pkg::*;
#(
  parameter int          XLEN     = 32,
  parameter int          CNT_W    = 32,
  parameter logic [31:0] NOP_WORD = 32'h0000_0013
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             idValid,
  input  logic [3:0]       brKind,
  input  logic [XLEN-1:0]  opA,
  input  logic [XLEN-1:0]  opB,
  input  logic [XLEN-1:0]  idPc,
  input  logic [XLEN-1:0]  immVal,
  input  logic [31:0]      ifInstr,
  output logic             takenOut,
  output logic [XLEN-1:0]  targetOut,
  output logic [XLEN-1:0]  linkOut,
  output logic             pcSel,
  output logic             flushOut,
  output logic [31:0]      ifidNext,
  output logic [CNT_W-1:0] brCount,
  output logic [CNT_W-1:0] takenCount
);

  strobe_t    strobe;
  cmp_flags_t flags;

  bru_ctrl u_ctrl (
    .idValid  (idValid),
    .brKind   (brKind),
    .flags    (flags),
    .strobe   (strobe),
    .takenOut (takenOut)
  );

  bru_datapath #(
    .XLEN     (XLEN),
    .CNT_W    (CNT_W),
    .NOP_WORD (NOP_WORD),
    .PC_STEP  (4)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .opA        (opA),
    .opB        (opB),
    .idPc       (idPc),
    .immVal     (immVal),
    .ifInstr    (ifInstr),
    .flags      (flags),
    .targetOut  (targetOut),
    .linkOut    (linkOut),
    .ifidNext   (ifidNext),
    .brCount    (brCount),
    .takenCount (takenCount)
  );

  assign pcSel    = strobe.redirect;
  assign flushOut = strobe.squash;

endmodule

// File: rtl/bru_checker.sv
module bru_checker #(
  parameter int          XLEN     = 32,
  parameter int          CNT_W    = 32,
  parameter logic [31:0] NOP_WORD = 32'h0000_0013
) (
  input logic             clk,
  input logic             rstN,
  input logic             idValid,
  input logic [3:0]       brKind,
  input logic [XLEN-1:0]  opA,
  input logic [XLEN-1:0]  opB,
  input logic [XLEN-1:0]  idPc,
  input logic [XLEN-1:0]  immVal,
  input logic             takenOut,
  input logic [XLEN-1:0]  targetOut,
  input logic             pcSel,
  input logic             flushOut,
  input logic [31:0]      ifidNext,
  input logic [CNT_W-1:0] brCount,
  input logic [CNT_W-1:0] takenCount
);

  logic isXfer;
  assign isXfer = idValid && (brKind >= 4'd1) && (brKind <= 4'd8);

  a_r1_eq_decision: assert property (@(posedge clk) disable iff (!rstN)
    (idValid && brKind == 4'd1) |-> (takenOut == (opA == opB)));

  a_r5_jump_taken: assert property (@(posedge clk) disable iff (!rstN)
    (idValid && brKind == 4'd7) |-> (takenOut && targetOut == idPc + immVal));

  a_r6_jreg_lsb: assert property (@(posedge clk) disable iff (!rstN)
    (idValid && brKind == 4'd8) |-> (takenOut && !targetOut[0]));

  a_r7_no_redirect: assert property (@(posedge clk) disable iff (!rstN)
    (!isXfer) |-> (!pcSel && !flushOut && !takenOut));

  a_r8_nop_fill: assert property (@(posedge clk) disable iff (!rstN)
    flushOut |-> (ifidNext == NOP_WORD));

  a_r9_count_step: assert property (@(posedge clk) disable iff (!rstN)
    isXfer |=> ((brCount == $past(brCount) + {{(CNT_W-1){1'b0}}, 1'b1})
                || ($past(brCount) == {CNT_W{1'b1}})));

  a_r10_taken_bound: assert property (@(posedge clk) disable iff (!rstN)
    takenCount <= brCount);

  a_r11_hold_max: assert property (@(posedge clk) disable iff (!rstN)
    (brCount == {CNT_W{1'b1}}) |=> (brCount == {CNT_W{1'b1}}));

endmodule

bind branch_resolve_unit bru_checker #(
  .XLEN     (XLEN),
  .CNT_W    (CNT_W),
  .NOP_WORD (NOP_WORD)
) u_bru_checker (
  .clk        (clk),
  .rstN       (rstN),
  .idValid    (idValid),
  .brKind     (brKind),
  .opA        (opA),
  .opB        (opB),
  .idPc       (idPc),
  .immVal     (immVal),
  .takenOut   (takenOut),
  .targetOut  (targetOut),
  .pcSel      (pcSel),
  .flushOut   (flushOut),
  .ifidNext   (ifidNext),
  .brCount    (brCount),
  .takenCount (takenCount)
);

// File: tb/branch_resolve_unit_bench.sv
module branch_resolve_unit_bench;

  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] NOP = 32'h0000_0013;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        idValid = 1'b0;
  logic [3:0]  brKind = 4'd0;
  logic [31:0] opA = '0, opB = '0, idPc = '0, immVal = '0, ifInstr = '0;

  logic        takenOut, pcSel, flushOut;
  logic [31:0] targetOut, linkOut, ifidNext, brCount, takenCount;
  logic        sTaken, sPcSel, sFlush;
  logic [31:0] sTarget, sLink, sNext;
  logic [3:0]  sBr, sTk;

  int errors = 0;
  int checks = 0;
  int mBr = 0;
  int mTk = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  branch_resolve_unit u_branch_resolve_unit (
    .clk(clk), .rstN(rstN), .idValid(idValid), .brKind(brKind),
    .opA(opA), .opB(opB), .idPc(idPc), .immVal(immVal), .ifInstr(ifInstr),
    .takenOut(takenOut), .targetOut(targetOut), .linkOut(linkOut),
    .pcSel(pcSel), .flushOut(flushOut), .ifidNext(ifidNext),
    .brCount(brCount), .takenCount(takenCount)
  );

  branch_resolve_unit #(.CNT_W(4)) u_small (
    .clk(clk), .rstN(rstN), .idValid(idValid), .brKind(brKind),
    .opA(opA), .opB(opB), .idPc(idPc), .immVal(immVal), .ifInstr(ifInstr),
    .takenOut(sTaken), .targetOut(sTarget), .linkOut(sLink),
    .pcSel(sPcSel), .flushOut(sFlush), .ifidNext(sNext),
    .brCount(sBr), .takenCount(sTk)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
    end
  endtask

  function automatic bit modelTaken(input logic v, input logic [3:0] k,
                                    input logic [31:0] a, input logic [31:0] b);
    if (!v) return 1'b0;
    case (k)
      4'd1: return a == b;
      4'd2: return a != b;
      4'd3: return $signed(a) < $signed(b);
      4'd4: return !($signed(a) < $signed(b));
      4'd5: return a < b;
      4'd6: return !(a < b);
      4'd7, 4'd8: return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

  task automatic apply(input string req, input logic v, input logic [3:0] k,
                       input logic [31:0] a, input logic [31:0] b,
                       input logic [31:0] pc, input logic [31:0] imm);
    bit          expT;
    logic [31:0] expTgt;
    bit          isX;
    @(negedge clk);
    idValid = v; brKind = k; opA = a; opB = b; idPc = pc; immVal = imm;
    ifInstr = pc ^ 32'hA5A5_0000;
    #1;
    expT = modelTaken(v, k, a, b);
    isX  = v && (k >= 4'd1) && (k <= 4'd8);
    chk({req, " taken"}, 32'(takenOut), 32'(expT));
    chk("R7 pcSel", 32'(pcSel), 32'(expT));
    chk("R7 flush", 32'(flushOut), 32'(expT));
    chk("R8 ifidNext", ifidNext, expT ? NOP : (pc ^ 32'hA5A5_0000));
    if (v && k == 4'd8) begin
      expTgt = (a + imm) & 32'hFFFF_FFFE;
      chk("R6 target", targetOut, expTgt);
    end else if (v && k >= 4'd1 && k <= 4'd7) begin
      chk("R4 target", targetOut, pc + imm);
    end
    if (v && k == 4'd7) chk("R5 link", linkOut, pc + 32'd4);
    @(posedge clk);
    #1;
    if (isX) mBr++;
    if (expT) mTk++;
    chk("R9 brCount", brCount, 32'(mBr));
    chk("R10 takenCount", takenCount, 32'(mTk));
    chk("R11 small brCount", 32'(sBr), (mBr > 15) ? 32'd15 : 32'(mBr));
    chk("R11 small takenCount", 32'(sTk), (mTk > 15) ? 32'd15 : 32'(mTk));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    chk("R12 reset brCount", brCount, 32'd0);
    chk("R12 reset takenCount", takenCount, 32'd0);
    @(negedge clk);
    rstN = 1'b1;

    apply("R1 eq equal",      1, 4'd1, 32'd7, 32'd7, 32'h0000_1000, 32'h0000_0040);
    apply("R1 eq differ",     1, 4'd1, 32'd7, 32'd8, 32'h0000_1004, 32'h0000_0040);
    apply("R1 ne differ",     1, 4'd2, 32'd7, 32'd8, 32'h0000_1008, 32'hFFFF_FFF0);
    apply("R1 ne equal",      1, 4'd2, 32'd9, 32'd9, 32'h0000_100C, 32'h0000_0010);
    apply("R2 lt neg",        1, 4'd3, 32'hFFFF_FFFF, 32'd1, 32'h0000_2000, 32'hFFFF_FF00);
    apply("R2 lt equal",      1, 4'd3, 32'd5, 32'd5, 32'h0000_2004, 32'h0000_0008);
    apply("R2 ge equal",      1, 4'd4, 32'd5, 32'd5, 32'h0000_2008, 32'h0000_0008);
    apply("R2 ge neg",        1, 4'd4, 32'h8000_0000, 32'd0, 32'h0000_200C, 32'h0000_0008);
    apply("R3 ltu big",       1, 4'd5, 32'hFFFF_FFFF, 32'd1, 32'h0000_3000, 32'h0000_0020);
    apply("R3 ltu small",     1, 4'd5, 32'd1, 32'hFFFF_FFFF, 32'h0000_3004, 32'h0000_0020);
    apply("R3 geu equal",     1, 4'd6, 32'd3, 32'd3, 32'h0000_3008, 32'hFFFF_FFFC);
    apply("R3 geu small",     1, 4'd6, 32'd2, 32'd3, 32'h0000_300C, 32'hFFFF_FFFC);
    apply("R5 jump back",     1, 4'd7, 32'd0, 32'd0, 32'h0000_4000, 32'hFFFF_F000);
    apply("R6 jreg odd",      1, 4'd8, 32'h0000_5001, 32'd0, 32'h0000_4004, 32'h0000_0002);
    apply("R6 jreg neg",      1, 4'd8, 32'h0000_5000, 32'd0, 32'h0000_4008, 32'hFFFF_FFFF);
    apply("R7 kind none",     1, 4'd0, 32'd1, 32'd1, 32'h0000_6000, 32'h0000_0010);
    apply("R7 kind unused",   1, 4'd12, 32'd1, 32'd1, 32'h0000_6004, 32'h0000_0010);
    apply("R7 invalid jump",  0, 4'd7, 32'd1, 32'd1, 32'h0000_6008, 32'h0000_0010);
    apply("R4 wrap",          1, 4'd1, 32'd0, 32'd0, 32'hFFFF_FFF0, 32'h0000_0020);

    for (int i = 0; i < 24; i++) begin
      apply("R11 saturate", 1, 4'((i % 8) + 1), 32'(i * 37), 32'(i * 11),
            32'h0000_8000 + 32'(i * 4), 32'(i * 8) - 32'd64);
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule